// File: doc/BRIEF.md
# Internal Control Register Bank

This block holds the privileged control registers of a processor core behind a single 8-bit index. Software-level microcode reads a register with a read strobe and gets the data and a fault flag back in the same cycle. It writes a register with a write strobe, and the write commits on the next rising clock edge. Each register applies its own write mask. Some registers clear themselves on any write. One register sets itself to one on any write. Registers that may only be read, or only be written, raise a fault when used in the wrong direction. An index with no register behind it also raises a fault.

A cycle-count register combines a stored upper half with the low 32 bits of a free-running counter supplied from outside. Software can therefore keep an offset in the upper word while the lower word always shows live time.

Top module: `ctl_regbank`

## Requirements
- R1: After reset, every register reads zero except the base register (index 24), which reads the parameter BASE_RESET, and the miscellaneous control register (index 48), which reads 6.
- R2: The full-width registers store all 64 bits of a write, and a later read returns exactly that value. These are the scratch registers at indices 0 to 23, base 24, performance 25, parity status 26 and 27, and miscellaneous control 48.
- R3: A write to the restart-address register (index 30) stores the data with bit 1 forced to zero.
- R4: Narrow masks apply to these registers: trap request (31) and trap enable (32) keep 0xf, priority level (33) keeps 0x1f, instruction and data mode (34, 35) keep 0x18, and software interrupt request (37) keeps 0x7fff0.
- R5: Wide masks apply to these registers: control/status (38) keeps 0xffffff0300, the two page-table bases (39, 40) keep 0xffffffffc0000000, cache test (41) keeps 0x1ffb, cache mode and miss mode (42, 43) keep 0x3f, instruction ASN (44) keeps 0x7f0, and data ASN (45) keeps 0xfe00000000000000.
- R6: Any write to exception summary (46) or exception mask (47) leaves it reading zero, whatever the data.
- R7: Any write to the counter-control register (28) leaves it reading 1, whatever the data.
- R8: A read of the cycle register (29) returns the stored bits 63:32 in the upper half and the live `cycle_lo` input in the lower half.
- R9: A write to a read-only index (49 to 53) raises `fault` and leaves the register unchanged. A read of such an index does not fault.
- R10: A read of a write-only index (36 and 54 to 63) raises `fault` and returns zero. A write to such an index does not fault.
- R11: Any access to an index of 64 or higher raises `fault`, and a read there returns zero.
- R12: With neither strobe asserted, `fault` is low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx | input | 8 | Register index |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, commits on the clock edge |
| wdata | input | 64 | Write data |
| cycle_lo | input | 32 | Live free-running cycle count, low word |
| rdata | output | 64 | Read data, combinational |
| fault | output | 1 | Illegal-access flag for the current strobe |

## Verification
The hardest case to reach is the clear-on-write registers. They can never hold a nonzero value, so a broken clear cannot be seen by reading back a value written earlier. The stimulus instead writes all-ones data to them and reads them back. A version that stored the data would then return nonzero. The counter merge is checked in a similar way. The stored upper word is loaded with a pattern that differs from the live counter, and the read is sampled while the counter runs, so a swap of the two halves or a stale low half shows up.

// File: rtl/ctl_regbank.sv
module ctl_regbank #(
  parameter int          DW         = 64,
  parameter int          IW         = 8,
  parameter int          CW         = 32,
  parameter logic [63:0] BASE_RESET = 64'h0000_0000_0001_0000,
  parameter logic [63:0] MISC_RESET = 64'h6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] idx,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] cycle_lo,
  output logic [DW-1:0] rdata,
  output logic          fault
);
  localparam int NSLOT = 64;
  localparam int SW    = $clog2(NSLOT);

  localparam int IX_BASE  = 24;
  localparam int IX_PERF  = 25;
  localparam int IX_IPAR  = 26;
  localparam int IX_DPAR  = 27;
  localparam int IX_CCTL  = 28;
  localparam int IX_CYC   = 29;
  localparam int IX_RST   = 30;
  localparam int IX_TREQ  = 31;
  localparam int IX_TEN   = 32;
  localparam int IX_LVL   = 33;
  localparam int IX_IMODE = 34;
  localparam int IX_DMODE = 35;
  localparam int IX_ALTM  = 36;
  localparam int IX_SWI   = 37;
  localparam int IX_CSR   = 38;
  localparam int IX_IPTB  = 39;
  localparam int IX_DPTB  = 40;
  localparam int IX_CTST  = 41;
  localparam int IX_CMODE = 42;
  localparam int IX_MMODE = 43;
  localparam int IX_IASN  = 44;
  localparam int IX_DASN  = 45;
  localparam int IX_XSUM  = 46;
  localparam int IX_XMSK  = 47;
  localparam int IX_MISC  = 48;
  localparam int IX_RO_LO = 49;
  localparam int IX_RO_HI = 53;
  localparam int IX_WO_LO = 54;

  logic [DW-1:0] bank [NSLOT];
  logic [DW-1:0] wmask;
  logic          in_range, is_ro, is_wo, clr_wr, set_wr;
  logic          rd_bad, wr_bad;
  logic [SW-1:0] slot;

  assign in_range = (idx < IW'(NSLOT));
  assign slot     = idx[SW-1:0];

  always_comb begin
    wmask  = '1;
    clr_wr = 1'b0;
    set_wr = 1'b0;
    is_ro  = 1'b0;
    is_wo  = 1'b0;
    if (in_range) begin
      if (int'(slot) >= IX_RO_LO && int'(slot) <= IX_RO_HI) is_ro = 1'b1;
      if (int'(slot) >= IX_WO_LO || int'(slot) == IX_ALTM)   is_wo = 1'b1;
      case (int'(slot))
        IX_RST:                   wmask = ~DW'(64'h2);
        IX_TREQ, IX_TEN:          wmask = DW'(64'hf);
        IX_LVL:                   wmask = DW'(64'h1f);
        IX_IMODE, IX_DMODE:       wmask = DW'(64'h18);
        IX_SWI:                   wmask = DW'(64'h7fff0);
        IX_CSR:                   wmask = DW'(64'hff_ffff_0300);
        IX_IPTB, IX_DPTB:         wmask = DW'(64'hffff_ffff_c000_0000);
        IX_CTST:                  wmask = DW'(64'h1ffb);
        IX_CMODE, IX_MMODE:       wmask = DW'(64'h3f);
        IX_IASN:                  wmask = DW'(64'h7f0);
        IX_DASN:                  wmask = DW'(64'hfe00_0000_0000_0000);
        IX_XSUM, IX_XMSK:         clr_wr = 1'b1;
        IX_CCTL:                  set_wr = 1'b1;
        default:                  wmask = '1;
      endcase
    end
  end

  assign rd_bad = !in_range || is_wo;
  assign wr_bad = !in_range || is_ro;
  assign fault  = (rd_en && rd_bad) || (wr_en && wr_bad);

  always_comb begin
    rdata = '0;
    if (rd_en && !rd_bad) begin
      if (int'(slot) == IX_CYC)
        rdata = {bank[IX_CYC][DW-1:CW], cycle_lo};
      else
        rdata = bank[slot];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        if (i == IX_BASE)      bank[i] <= BASE_RESET;
        else if (i == IX_MISC) bank[i] <= MISC_RESET;
        else                   bank[i] <= '0;
      end
    end else if (wr_en && !wr_bad && !is_wo) begin
      if (clr_wr)      bank[slot] <= '0;
      else if (set_wr) bank[slot] <= DW'(1);
      else             bank[slot] <= wdata & wmask;
    end
  end
endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  idx,
  input logic        rd_en,
  input logic        wr_en,
  input logic [63:0] rdata,
  input logic        fault,
  input logic [31:0] cycle_lo,
  input logic [63:0] restart_q,
  input logic [63:0] level_q,
  input logic [63:0] xsum_q,
  input logic [63:0] cctl_q
);
  p_restart_bit1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q[1] == 1'b0);

  p_level_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level_q[63:5] == '0);

  p_clear_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 8'd46) |=> xsum_q == '0);

  p_cctl_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 8'd28) |=> cctl_q == 64'd1);

  p_cycle_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx == 8'd29) |-> rdata[31:0] == cycle_lo);

  p_ro_write_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx >= 8'd49 && idx <= 8'd53) |-> fault);

  p_wo_read_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx >= 8'd54 && idx <= 8'd63) |-> (fault && rdata == '0));

  p_oob_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && idx >= 8'd64) |-> fault);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |-> (!fault && rdata == '0));
endmodule

bind ctl_regbank ctl_regbank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idx       (idx),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .rdata     (rdata),
  .fault     (fault),
  .cycle_lo  (cycle_lo),
  .restart_q (bank[30]),
  .level_q   (bank[33]),
  .xsum_q    (bank[46]),
  .cctl_q    (bank[28])
);

// File: tb/ctl_regbank_tb.sv
`timescale 1ns/1ps
module ctl_regbank_tb;
  localparam logic [63:0] BASE_RST = 64'h0000_0000_0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  idx = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wdata = '0;
  logic [31:0] cyc = 32'hffff_ff00;
  logic [63:0] rdata;
  logic        fault;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 32'd1;

  ctl_regbank #(.BASE_RESET(BASE_RST)) u_dut (
    .clk(clk), .rst_n(rst_n), .idx(idx), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .cycle_lo(cyc), .rdata(rdata), .fault(fault));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] i, input logic [63:0] d, output logic f);
    @(negedge clk);
    idx = i; wdata = d; rd_en = 1'b0; wr_en = 1'b1;
    #1 f = fault;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] i, output logic [63:0] v, output logic f);
    @(negedge clk);
    idx = i; rd_en = 1'b1; wr_en = 1'b0;
    #1 v = rdata; f = fault;
    rd_en = 1'b0;
  endtask

  task automatic wr_rd(input string req, input logic [7:0] i, input logic [63:0] d,
                       input logic [63:0] exp);
    logic f; logic [63:0] v;
    wr(i, d, f);
    chk({req, " write fault"}, {63'd0, f}, 64'd0);
    rd(i, v, f);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    logic [63:0] v; logic f;
    rd(8'd24, v, f); chk("R1 base", v, BASE_RST);
    rd(8'd48, v, f); chk("R1 misc", v, 64'd6);
    rd(8'd5, v, f);  chk("R1 scratch", v, 64'd0);
    rd(8'd33, v, f); chk("R1 level", v, 64'd0);
  endtask

  task automatic t_full;
    wr_rd("R2 scratch0", 8'd0, 64'hdead_beef_0123_4567, 64'hdead_beef_0123_4567);
    wr_rd("R2 scratch23", 8'd23, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff);
    wr_rd("R2 base", 8'd24, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001);
    wr_rd("R2 misc", 8'd48, 64'h55aa_55aa_55aa_55aa, 64'h55aa_55aa_55aa_55aa);
  endtask

  task automatic t_restart;
    wr_rd("R3 restart ones", 8'd30, '1, ~64'h2);
    wr_rd("R3 restart pattern", 8'd30, 64'h1234_5677, 64'h1234_5675);
  endtask

  task automatic t_narrow;
    wr_rd("R4 trap req", 8'd31, '1, 64'hf);
    wr_rd("R4 trap en", 8'd32, '1, 64'hf);
    wr_rd("R4 level", 8'd33, '1, 64'h1f);
    wr_rd("R4 imode", 8'd34, '1, 64'h18);
    wr_rd("R4 dmode", 8'd35, 64'h0f, 64'h08);
    wr_rd("R4 swint", 8'd37, '1, 64'h7fff0);
  endtask

  task automatic t_wide;
    wr_rd("R5 csr", 8'd38, '1, 64'hff_ffff_0300);
    wr_rd("R5 iptb", 8'd39, '1, 64'hffff_ffff_c000_0000);
    wr_rd("R5 dptb", 8'd40, 64'h0000_0001_4000_0000, 64'h0000_0001_4000_0000);
    wr_rd("R5 ctest", 8'd41, '1, 64'h1ffb);
    wr_rd("R5 cmode", 8'd42, '1, 64'h3f);
    wr_rd("R5 mmode", 8'd43, '1, 64'h3f);
    wr_rd("R5 iasn", 8'd44, '1, 64'h7f0);
    wr_rd("R5 dasn", 8'd45, '1, 64'hfe00_0000_0000_0000);
  endtask

  task automatic t_clear;
    wr_rd("R6 xsum", 8'd46, '1, 64'd0);
    wr_rd("R6 xmask", 8'd47, 64'h8000_0000_0000_00ff, 64'd0);
  endtask

  task automatic t_cctl;
    wr_rd("R7 cctl zero data", 8'd28, 64'd0, 64'd1);
    wr_rd("R7 cctl ones", 8'd28, '1, 64'd1);
  endtask

  task automatic t_cycle;
    logic f; logic [63:0] v;
    wr(8'd29, 64'h1234_5678_9abc_def0, f);
    chk("R8 write fault", {63'd0, f}, 64'd0);
    for (int k = 0; k < 3; k++) begin
      rd(8'd29, v, f);
      chk("R8 cycle merge", v, {32'h1234_5678, cyc});
    end
  endtask

  task automatic t_ro;
    logic f; logic [63:0] v;
    for (int k = 49; k <= 53; k++) begin
      wr(8'(k), '1, f);
      chk("R9 ro write fault", {63'd0, f}, 64'd1);
      rd(8'(k), v, f);
      chk("R9 ro value", v, 64'd0);
      chk("R9 ro read ok", {63'd0, f}, 64'd0);
    end
  endtask

  task automatic t_wo;
    logic f; logic [63:0] v;
    wr(8'd54, '1, f);
    chk("R10 wo write ok", {63'd0, f}, 64'd0);
    rd(8'd54, v, f);
    chk("R10 wo read fault", {63'd0, f}, 64'd1);
    chk("R10 wo read data", v, 64'd0);
    wr(8'd36, '1, f);
    rd(8'd36, v, f);
    chk("R10 altmode read fault", {63'd0, f}, 64'd1);
    rd(8'd63, v, f);
    chk("R10 last wo read fault", {63'd0, f}, 64'd1);
  endtask

  task automatic t_oob;
    logic f; logic [63:0] v;
    rd(8'd64, v, f);
    chk("R11 read fault", {63'd0, f}, 64'd1);
    chk("R11 read data", v, 64'd0);
    wr(8'd200, '1, f);
    chk("R11 write fault", {63'd0, f}, 64'd1);
    wr(8'd64, 64'h77, f);
    chk("R11 write 64 fault", {63'd0, f}, 64'd1);
    rd(8'd0, v, f);
    chk("R11 no alias into slot 0", v, 64'hdead_beef_0123_4567);
  endtask

  task automatic t_idle;
    @(negedge clk);
    idx = 8'd64; rd_en = 1'b0; wr_en = 1'b0;
    #1 chk("R12 idle fault", {63'd0, fault}, 64'd0);
    idx = 8'd24;
    #1 chk("R12 idle rdata", rdata, 64'd0);
  endtask

  initial begin
    #1 chk("R12 reset fault", {63'd0, fault}, 64'd0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset; t_full; t_restart; t_narrow; t_wide; t_clear;
    t_cctl; t_cycle; t_ro; t_wo; t_oob; t_idle;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule